// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the software-visible registers of a single DMA channel. A word-wide slave port reaches four 32-bit registers: a control/status word, a transfer address, and two general-purpose words. Writes to the control word are interpreted rather than simply stored. A reset request produces a one-clock pulse toward the attached peripheral. A drain request clears itself. An all-zero write becomes a drain request. Changes of the enable bit drive a DMA-enable level. A fixed read-only field, which includes the version code, survives every write.

The block takes a level interrupt request from the channel and records it as the pending flag. It raises its interrupt output only while that flag and the interrupt-enable bit are both set. When the data mover reports that a transfer has finished, it gives a byte count, and the address register advances by that amount. A parameter selects the network-side variant, which answers over a 32-byte window.

Two small state machines sit inside the control unit. The reset sequencer has the states PR_QUIET and PR_PULSE. It moves PR_QUIET to PR_PULSE on a control write that carries the reset bit, and it always returns PR_PULSE to PR_QUIET on the next clock. The enable tracker has the states EN_IDLE and EN_ACTIVE. It moves EN_IDLE to EN_ACTIVE on a control write with the enable bit set, and it moves EN_ACTIVE to EN_IDLE on a control write with that bit clear.

Top module: `dmacr_top`

## Requirements
- R1: Byte-offset bits [3:2] select the register: 0 is control, 1 is transfer address, 2 and 3 are general words. Bits [1:0] are ignored. After reset the control word reads 0xA0000000 and the other three read 0.
- R2: On a control write, the bits under mask 0xFE000007 keep their previous value, and 0xA0000000 is ORed into the stored word. The other bits take the written value, as changed by R3 and R4.
- R3: A control write with bit 7 set drives `periph_rst` high for exactly the one cycle after the write edge. Bit 7 is stored as written. A second request that lands during the pulse cycle merges into that pulse.
- R4: When bit 7 is clear, a control write with bit 6 set stores bit 6 as 0. A control write of exactly 0 stores 0x00000040.
- R5: `dma_en` rises after a control write takes bit 9 from 0 to 1 and falls after a control write takes it from 1 to 0. Otherwise it holds.
- R6: A write to the address register sets control bit 26. Because bit 26 is read-only, only reset clears it.
- R7: Control bit 0 (pending) takes the value of `irq_req_in` sampled at each clock edge.
- R8: `irq_out` is high exactly while control bit 0 and bit 4 (interrupt enable) are both set. It changes in the same cycle as those bits.
- R9: A `xfer_done` strobe adds `xfer_bytes` to the address register. If the bus writes the address register in the same cycle, the written value wins. A bus write to any other register does not block the add.
- R10: With NET_MODE=1, offsets 0x10–0x1F alias the four registers, offsets above 0x1F read 0, and writes to them change nothing. With NET_MODE=0, every offset aliases modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_req_in | input | 1 | Interrupt request level from the channel |
| irq_out | output | 1 | Interrupt to the system |
| xfer_done | input | 1 | Transfer-complete strobe |
| xfer_bytes | input | CNT_W | Bytes moved by the finished transfer |
| periph_rst | output | 1 | One-cycle peripheral reset pulse |
| dma_en | output | 1 | DMA-enable level |

## Verification
The bench drives the interpreted control writes back to back, in this order: zero, drain only, reset with drain, all ones, and enable-only.
- A design that tested drain before reset, or tested the zero case on the altered value, would store a wrong bit 6.
- A design that let read-only bits through would lose the version code or the loaded flag.

The bench then checks the interrupt path.
- It clears the enable bit while a request is pending.
- It sets the enable bit again with the request still present.
- A masked or late output would show up as a mismatch on `irq_out`.

The bench checks the address register three ways.
- It fires a transfer-done strobe together with an address write, where the write must win.
- It fires the strobe together with a general-register write, where the add must still happen.

Finally, the bench probes the alias window and the region above it. A decoder that wrapped the upper offsets would corrupt the general words.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
    localparam int unsigned REG_W   = 32;
    localparam logic [31:0] VERSION = 32'hA000_0000;
    localparam logic [31:0] RO_MASK = 32'hFE00_0007;

    localparam int unsigned B_PEND   = 0;
    localparam int unsigned B_IEN    = 4;
    localparam int unsigned B_DRAIN  = 6;
    localparam int unsigned B_PRST   = 7;
    localparam int unsigned B_TOMEM  = 8;
    localparam int unsigned B_DEN    = 9;
    localparam int unsigned B_LOADED = 26;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_ADDR = 2'd1,
        IDX_GP0  = 2'd2,
        IDX_GP1  = 2'd3
    } reg_idx_e;

    typedef enum logic {
        PR_QUIET = 1'b0,
        PR_PULSE = 1'b1
    } prst_state_e;

    typedef enum logic {
        EN_IDLE   = 1'b0,
        EN_ACTIVE = 1'b1
    } den_state_e;
endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
    import dmacr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned NET_MODE = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_idx_e          idx,
    output logic              hit
);
    localparam int unsigned WIN_BITS = 5;

    assign idx = reg_idx_e'(addr[3:2]);

    generate
        if (NET_MODE != 0 && ADDR_W > WIN_BITS) begin : g_net_window
            assign hit = ~|addr[ADDR_W-1:WIN_BITS];
        end else begin : g_full_alias
            assign hit = 1'b1;
        end
    endgenerate

    initial begin
        assert (ADDR_W >= 4) else $error("ADDR_W too small to select registers");
    end
endmodule

// File: rtl/dmacr_ctrl.sv
module dmacr_ctrl
    import dmacr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              load_set,
    input  logic              irq_req,
    output logic [REG_W-1:0]  ctrl_q,
    output logic              periph_rst,
    output logic              dma_en
);
    prst_state_e      prst_q, prst_d;
    den_state_e       den_q, den_d;
    logic             reset_req;
    logic [REG_W-1:0] req_val;
    logic [REG_W-1:0] ctrl_d;

    // interpret the written word: reset beats drain, drain beats zero
    always_comb begin
        req_val   = wdata;
        reset_req = 1'b0;
        if (wdata[B_PRST]) begin
            reset_req = 1'b1;
        end else if (wdata[B_DRAIN]) begin
            req_val[B_DRAIN] = 1'b0;
        end else if (wdata == '0) begin
            req_val[B_DRAIN] = 1'b1;
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = (ctrl_q & RO_MASK) | (req_val & ~RO_MASK) | VERSION;
        end
        ctrl_d[B_PEND] = irq_req;
        if (load_set) begin
            ctrl_d[B_LOADED] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= VERSION;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // next-state logic for both sequencers
    always_comb begin
        prst_d = prst_q;
        unique case (prst_q)
            PR_QUIET: if (wr_en && reset_req) prst_d = PR_PULSE;
            PR_PULSE: prst_d = PR_QUIET;
        endcase
        den_d = den_q;
        unique case (den_q)
            EN_IDLE:   if (wr_en && wdata[B_DEN])  den_d = EN_ACTIVE;
            EN_ACTIVE: if (wr_en && !wdata[B_DEN]) den_d = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prst_q <= PR_QUIET;
            den_q  <= EN_IDLE;
        end else begin
            prst_q <= prst_d;
            den_q  <= den_d;
        end
    end

    always_comb begin
        periph_rst = (prst_q == PR_PULSE);
        dma_en     = (den_q == EN_ACTIVE);
    end

    p_pulse_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |=> !periph_rst);
    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_rst) |-> $past(wr_en && wdata[B_PRST]));
    p_en_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_en) |-> $past(wr_en && wdata[B_DEN]));
    p_en_tracks_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en == ctrl_q[B_DEN]);
    p_version_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[31:29] == 3'b101);
    p_loaded_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(ctrl_q[B_LOADED])) |-> ctrl_q[B_LOADED]);
endmodule

// File: rtl/dmacr_addr.sv
module dmacr_addr
    import dmacr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              done,
    input  logic [CNT_W-1:0]  bytes,
    output logic [REG_W-1:0]  addr_q
);
    localparam int unsigned PAD_W = REG_W - CNT_W;

    logic [REG_W-1:0] step;
    assign step = {{PAD_W{1'b0}}, bytes};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en) begin
            addr_q <= wdata;
        end else if (done) begin
            addr_q <= addr_q + step;
        end
    end

    p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(done && !wr_en)) |-> addr_q == $past(addr_q) + $past(step));
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> addr_q == $past(wdata));
endmodule

// File: rtl/dmacr_gpregs.sv
module dmacr_gpregs
    import dmacr_pkg::*;
#(
    parameter int unsigned NUM_GP = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GP-1:0]             wr_en,
    input  logic [REG_W-1:0]              wdata,
    output logic [NUM_GP-1:0][REG_W-1:0]  gp_q
);
    generate
        for (genvar g = 0; g < NUM_GP; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    gp_q[g] <= '0;
                end else if (wr_en[g]) begin
                    gp_q[g] <= wdata;
                end
            end
        end
    endgenerate

    p_hold_unwritten_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(|wr_en)) |-> $stable(gp_q));
endmodule

// File: rtl/dmacr_top.sv
module dmacr_top
    import dmacr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned NET_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              irq_req_in,
    output logic              irq_out,
    input  logic              xfer_done,
    input  logic [CNT_W-1:0]  xfer_bytes,
    output logic              periph_rst,
    output logic              dma_en
);
    localparam int unsigned NUM_GP = 2;

    reg_idx_e                     idx;
    logic                         hit;
    logic                         wr_ok;
    logic                         ctrl_wr, addr_wr;
    logic [NUM_GP-1:0]            gp_wr;
    logic [REG_W-1:0]             ctrl_q, addr_q;
    logic [NUM_GP-1:0][REG_W-1:0] gp_q;

    dmacr_decode #(.ADDR_W(ADDR_W), .NET_MODE(NET_MODE)) u_decode (
        .addr (bus_addr),
        .idx  (idx),
        .hit  (hit)
    );

    assign wr_ok    = bus_sel && bus_wr && hit;
    assign ctrl_wr  = wr_ok && (idx == IDX_CTRL);
    assign addr_wr  = wr_ok && (idx == IDX_ADDR);
    assign gp_wr[0] = wr_ok && (idx == IDX_GP0);
    assign gp_wr[1] = wr_ok && (idx == IDX_GP1);

    dmacr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .wdata      (bus_wdata),
        .load_set   (addr_wr),
        .irq_req    (irq_req_in),
        .ctrl_q     (ctrl_q),
        .periph_rst (periph_rst),
        .dma_en     (dma_en)
    );

    dmacr_addr #(.CNT_W(CNT_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (addr_wr),
        .wdata  (bus_wdata),
        .done   (xfer_done),
        .bytes  (xfer_bytes),
        .addr_q (addr_q)
    );

    dmacr_gpregs #(.NUM_GP(NUM_GP)) u_gp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (gp_wr),
        .wdata (bus_wdata),
        .gp_q  (gp_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && hit) begin
            unique case (idx)
                IDX_CTRL: bus_rdata = ctrl_q;
                IDX_ADDR: bus_rdata = addr_q;
                IDX_GP0:  bus_rdata = gp_q[0];
                IDX_GP1:  bus_rdata = gp_q[1];
            endcase
        end
    end

    assign irq_out = ctrl_q[B_PEND] & ctrl_q[B_IEN];

    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_req_in) && ctrl_q[B_IEN]) |-> irq_out);
    p_irq_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(irq_req_in)) |-> !irq_out);
    p_loaded_on_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr_wr)) |-> ctrl_q[B_LOADED]);
endmodule

// File: tb/test_dmacr_top.sv
module test_dmacr_top;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned CNT_W  = 16;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq_out, 2 periph_rst, 3 dma_en
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_req_in = 1'b0, irq_out;
    logic              xfer_done = 1'b0;
    logic [CNT_W-1:0]  xfer_bytes = '0;
    logic              periph_rst, dma_en;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    all_done = 1'b0;

    always #5 clk = ~clk;

    dmacr_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NET_MODE(1)) i_dmacr_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req_in(irq_req_in), .irq_out(irq_out), .xfer_done(xfer_done),
        .xfer_bytes(xfer_bytes), .periph_rst(periph_rst), .dma_en(dma_en)
    );

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, irq_out};
                2:       act = {31'd0, periph_rst};
                default: act = {31'd0, dma_en};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_sig(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle_bus();
        bus_sel = 1'b0; bus_wr = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        idle_bus();
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        expect_sig(0, exp, tag);
        @(posedge clk); #1;
        idle_bus();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(6'h00, 32'hA000_0000, "R1 ctrl reset");
        rd(6'h04, 32'h0, "R1 addr reset");
        rd(6'h08, 32'h0, "R1 gp0 reset");
        rd(6'h0C, 32'h0, "R1 gp1 reset");
        expect_sig(1, 0, "R8 irq reset");
        expect_sig(2, 0, "R3 rst reset");
        expect_sig(3, 0, "R5 en reset");

        // R1 general words and low offset bits
        wr(6'h08, 32'h1234_5678);
        wr(6'h0C, 32'h9ABC_DEF0);
        rd(6'h0B, 32'h1234_5678, "R1 gp0 low bits ignored");
        rd(6'h0C, 32'h9ABC_DEF0, "R1 gp1");

        // R6 address write sets loaded bit
        wr(6'h04, 32'h0000_1000);
        rd(6'h04, 32'h0000_1000, "R1 addr");
        rd(6'h00, 32'hA400_0000, "R6 loaded set");

        // R9 transfer-done advance
        @(posedge clk); #1 xfer_done = 1'b1; xfer_bytes = 16'h0020;
        @(posedge clk); #1 idle_bus();
        rd(6'h04, 32'h0000_1020, "R9 advance");
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h0000_5000;
        xfer_done = 1'b1; xfer_bytes = 16'h0100;
        @(posedge clk); #1 idle_bus();
        rd(6'h04, 32'h0000_5000, "R9 write wins");
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 32'h0000_00AA;
        xfer_done = 1'b1; xfer_bytes = 16'h0008;
        @(posedge clk); #1 idle_bus();
        rd(6'h04, 32'h0000_5008, "R9 other write does not block");
        rd(6'h08, 32'h0000_00AA, "R9 gp0 written alongside");

        // R4 drain handling
        wr(6'h00, 32'h0);
        rd(6'h00, 32'hA400_0040, "R4 zero becomes drain");
        wr(6'h00, 32'h0000_0040);
        rd(6'h00, 32'hA400_0000, "R4 drain self-clears");

        // R3 reset pulse, drain kept with reset
        wr(6'h00, 32'h0000_00C0);
        expect_sig(2, 1, "R3 pulse high");
        @(posedge clk); #1;
        expect_sig(2, 0, "R3 pulse one cycle");
        rd(6'h00, 32'hA400_00C0, "R3 R4 reset beats drain");

        // R2 read-only bits and R5 enable edges
        wr(6'h00, 32'hFFFF_FFFF);
        expect_sig(3, 1, "R5 enable rises");
        expect_sig(2, 1, "R3 pulse on all ones");
        rd(6'h00, 32'hA5FF_FFF8, "R2 ro bits kept");
        wr(6'h00, 32'h0000_0200);
        expect_sig(3, 1, "R5 enable holds");
        rd(6'h00, 32'hA400_0200, "R2 version kept");
        wr(6'h00, 32'h0000_0010);
        expect_sig(3, 0, "R5 enable falls");

        // R7 R8 interrupt path
        @(posedge clk); #1 irq_req_in = 1'b1;
        @(posedge clk); #1;
        expect_sig(1, 1, "R8 irq raised");
        rd(6'h00, 32'hA400_0011, "R7 pending set");
        wr(6'h00, 32'h0);
        expect_sig(1, 0, "R8 irq masked");
        rd(6'h00, 32'hA400_0041, "R7 pending survives write");
        wr(6'h00, 32'h0000_0010);
        expect_sig(1, 1, "R8 irq re-enabled");
        @(posedge clk); #1 irq_req_in = 1'b0;
        @(posedge clk); #1;
        expect_sig(1, 0, "R7 R8 irq cleared");
        rd(6'h00, 32'hA400_0010, "R7 pending cleared");

        // R10 network window
        wr(6'h18, 32'hCAFE_0001);
        rd(6'h08, 32'hCAFE_0001, "R10 alias write");
        rd(6'h14, 32'h0000_5008, "R10 alias read");
        rd(6'h24, 32'h0, "R10 above window reads zero");
        wr(6'h28, 32'h0000_DEAD);
        rd(6'h08, 32'hCAFE_0001, "R10 write above window ignored");
        rd(6'h28, 32'h0, "R10 above window still zero");

        @(posedge clk); @(posedge clk);
        all_done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!all_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule